// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Preload

This block is a single channel of a general-purpose timer. It sits beside a shared free-running counter and either compares that counter against a programmed threshold to shape a digital output, or takes a snapshot of the counter when an external capture strobe arrives. Software reaches the channel through one data register. The direction input picks between the two uses.

In output direction, a software write lands in a shadow (preload) register. When preload is enabled, the live compare threshold is refreshed from the shadow only when the timer's update event pulses. Otherwise the threshold follows every write on the same clock edge. The live threshold drives four waveform behaviours: hold, toggle on match, and two PWM polarities. It also sets a sticky match flag.

In input direction, the same data register holds the most recent captured counter value, and software writes to it are dropped. A capture that arrives while the channel flag is still set also raises a sticky overcapture flag.

Top module: `cc_channel`

## Requirements
- R1: After reset, the data register reads 0, the live threshold is 0, and the channel output, channel flag and overcapture flag are all 0.
- R2: In output direction (dir_i=0) with preload disabled (preload_en_i=0), a write updates the data register and the live threshold on the same clock edge. The next comparison uses the new value.
- R3: In output direction with preload enabled (preload_en_i=1), a write updates only the data register. The live threshold keeps its value until a cycle with upd_i=1, when it takes the data register's value from before that edge.
- R4: Output mode code 2 (PWM, high below threshold) registers ch_out_o=1 when cnt_i < threshold and 0 otherwise. Code 3 (inverted PWM) registers the opposite. The output changes one clock after the counter value is presented.
- R5: Output mode code 1 flips ch_out_o on each clock where cnt_i equals the threshold. Code 0 holds ch_out_o unchanged.
- R6: In output direction, cnt_i equal to the threshold sets cc_flag_o on the next edge. The flag stays set until clr_cc_i=1, and a new set in the same cycle as a clear wins.
- R7: In input direction (dir_i=1), cap_evt_i=1 stores cnt_i in the data register on that edge and sets cc_flag_o.
- R8: A capture while cc_flag_o is already 1 sets ovc_flag_o and still overwrites the data register. ovc_flag_o is cleared only by clr_ovc_i=1.
- R9: In input direction, wr_i has no effect on the data register.
- R10: In input direction, ch_out_o is 0 and counter matches do not set cc_flag_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Shared timer counter value |
| upd_i | input | 1 | Timer update event pulse |
| dir_i | input | 1 | 0 = output compare, 1 = input capture |
| oc_mode_i | input | 2 | Output behaviour: 0 hold, 1 toggle, 2 PWM, 3 inverted PWM |
| preload_en_i | input | 1 | Gate threshold refresh on the update event |
| wr_i | input | 1 | Data register write strobe |
| wdata_i | input | 16 | Data register write value |
| rdata_o | output | 16 | Data register contents (shadow value or capture) |
| cap_evt_i | input | 1 | Capture strobe |
| clr_cc_i | input | 1 | Clear channel flag |
| clr_ovc_i | input | 1 | Clear overcapture flag |
| ch_out_o | output | 1 | Channel output waveform |
| cc_flag_o | output | 1 | Sticky match/capture flag |
| ovc_flag_o | output | 1 | Sticky overcapture flag |

## Verification
The counter is placed below, at, and above the threshold under both PWM polarities. These cases separate a strict less-than comparison from a less-or-equal one and confirm the inverted polarity. Writes are issued with preload off and with preload on, and the counter is held fixed across the update pulse. Because of this, the output level alone shows whether the threshold moved at the write or at the update. Repeated matches in toggle and hold modes, clears that coincide with a match, and back-to-back captures with and without a pending flag separate set-over-clear priority, toggling and overcapture detection. A write and a matching counter value in input direction show that neither reaches the register or the flag.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        OC_HOLD   = 2'd0,
        OC_TOGGLE = 2'd1,
        OC_PWM_LO = 2'd2,
        OC_PWM_HI = 2'd3
    } oc_mode_e;

    typedef struct packed {
        logic cc;
        logic ovc;
    } ch_flags_t;

    // Registered output level for a given behaviour.
    function automatic logic next_level(oc_mode_e m, logic below, logic hit, logic cur);
        logic r;
        case (m)
            OC_TOGGLE: r = hit ? ~cur : cur;
            OC_PWM_LO: r = below;
            OC_PWM_HI: r = ~below;
            default:   r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cc_data_regs.sv
module cc_data_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_i,
    input  logic         preload_en_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         upd_i,
    input  logic         cap_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] shadow_q,
    output logic [W-1:0] act_q
);

    // Data register: shadow in output direction, capture latch in input direction.
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (dir_i) begin
            if (cap_i) shadow_q <= cnt_i;
        end else if (wr_i) begin
            shadow_q <= wdata_i;
        end
    end

    // Live threshold.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else if (!dir_i) begin
            if (!preload_en_i && wr_i)      act_q <= wdata_i;
            else if (preload_en_i && upd_i) act_q <= shadow_q;
        end
    end

endmodule

// File: rtl/cc_compare.sv
module cc_compare
    import cc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir_i,
    input  oc_mode_e     mode_i,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] act_i,
    output logic         hit_o,
    output logic         out_q
);

    logic below;

    assign below = (cnt_i < act_i);
    assign hit_o = !dir_i && (cnt_i == act_i);

    always_ff @(posedge clk) begin
        if (rst || dir_i) out_q <= 1'b0;
        else              out_q <= next_level(mode_i, below, hit_o, out_q);
    end

endmodule

// File: rtl/cc_flags.sv
module cc_flags
    import cc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hit_i,
    input  logic      cap_i,
    input  logic      clr_cc_i,
    input  logic      clr_ovc_i,
    output ch_flags_t flags_q
);

    logic set_cc;

    assign set_cc = hit_i || cap_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            if (set_cc)        flags_q.cc <= 1'b1;
            else if (clr_cc_i) flags_q.cc <= 1'b0;

            if (cap_i && flags_q.cc) flags_q.ovc <= 1'b1;
            else if (clr_ovc_i)      flags_q.ovc <= 1'b0;
        end
    end

endmodule

// File: rtl/cc_channel.sv
module cc_channel
    import cc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             upd_i,
    input  logic             dir_i,
    input  logic [1:0]       oc_mode_i,
    input  logic             preload_en_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o,
    input  logic             cap_evt_i,
    input  logic             clr_cc_i,
    input  logic             clr_ovc_i,
    output logic             ch_out_o,
    output logic             cc_flag_o,
    output logic             ovc_flag_o
);

    oc_mode_e         mode;
    logic [CNT_W-1:0] shadow_q;
    logic [CNT_W-1:0] act_q;
    logic             hit;
    logic             cap;
    ch_flags_t        flags;

    assign mode = oc_mode_e'(oc_mode_i);
    assign cap  = dir_i && cap_evt_i;

    cc_data_regs #(.W(CNT_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .dir_i        (dir_i),
        .preload_en_i (preload_en_i),
        .wr_i         (wr_i),
        .wdata_i      (wdata_i),
        .upd_i        (upd_i),
        .cap_i        (cap),
        .cnt_i        (cnt_i),
        .shadow_q     (shadow_q),
        .act_q        (act_q)
    );

    cc_compare #(.W(CNT_W)) u_cmp (
        .clk    (clk),
        .rst    (rst),
        .dir_i  (dir_i),
        .mode_i (mode),
        .cnt_i  (cnt_i),
        .act_i  (act_q),
        .hit_o  (hit),
        .out_q  (ch_out_o)
    );

    cc_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .hit_i     (hit),
        .cap_i     (cap),
        .clr_cc_i  (clr_cc_i),
        .clr_ovc_i (clr_ovc_i),
        .flags_q   (flags)
    );

    assign rdata_o    = shadow_q;
    assign cc_flag_o  = flags.cc;
    assign ovc_flag_o = flags.ovc;

endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk
    import cc_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] cnt_i,
    input logic         upd_i,
    input logic         dir_i,
    input logic [1:0]   oc_mode_i,
    input logic         preload_en_i,
    input logic         cap_evt_i,
    input logic         clr_cc_i,
    input logic         clr_ovc_i,
    input logic [W-1:0] rdata_o,
    input logic [W-1:0] act_q,
    input logic         ch_out_o,
    input logic         cc_flag_o,
    input logic         ovc_flag_o
);

    // R1: state is cleared on the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rdata_o == '0 && act_q == '0 && !ch_out_o && !cc_flag_o && !ovc_flag_o));

    // R3: threshold holds while preload is on and no update pulses
    p_preload_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (preload_en_i && !upd_i) |=> $stable(act_q));

    // R4: PWM output follows the counter against the threshold one clock later
    p_pwm_level_r4: assert property (@(posedge clk) disable iff (rst)
        (!dir_i && oc_mode_i == 2'd2) |=> (ch_out_o == ($past(cnt_i) < $past(act_q))));

    // R5: hold mode keeps the output
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!dir_i && oc_mode_i == 2'd0) |=> $stable(ch_out_o));

    // R6: channel flag is sticky without a clear
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (cc_flag_o && !clr_cc_i) |=> cc_flag_o);

    // R7: capture stores the counter and raises the flag
    p_capture_r7: assert property (@(posedge clk) disable iff (rst)
        (dir_i && cap_evt_i) |=> (rdata_o == $past(cnt_i) && cc_flag_o));

    // R8: capture on a pending flag raises overcapture
    p_overcap_r8: assert property (@(posedge clk) disable iff (rst)
        (dir_i && cap_evt_i && cc_flag_o) |=> ovc_flag_o);

    // R9: no capture in input direction leaves the register alone
    p_wr_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (dir_i && !cap_evt_i) |=> $stable(rdata_o));

    // R10: output is low in input direction
    p_in_low_r10: assert property (@(posedge clk) disable iff (rst)
        dir_i |=> !ch_out_o);

endmodule

bind cc_channel cc_channel_chk #(.W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cnt_i        (cnt_i),
    .upd_i        (upd_i),
    .dir_i        (dir_i),
    .oc_mode_i    (oc_mode_i),
    .preload_en_i (preload_en_i),
    .cap_evt_i    (cap_evt_i),
    .clr_cc_i     (clr_cc_i),
    .clr_ovc_i    (clr_ovc_i),
    .rdata_o      (rdata_o),
    .act_q        (act_q),
    .ch_out_o     (ch_out_o),
    .cc_flag_o    (cc_flag_o),
    .ovc_flag_o   (ovc_flag_o)
);

// File: tb/tb_cc_channel.sv
`timescale 1ns/1ps
module tb_cc_channel;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cnt_i;
    logic        upd_i, dir_i, preload_en_i, wr_i, cap_evt_i, clr_cc_i, clr_ovc_i;
    logic [1:0]  oc_mode_i;
    logic [15:0] wdata_i, rdata_o;
    logic        ch_out_o, cc_flag_o, ovc_flag_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    cc_channel dut (
        .clk(clk), .rst(rst), .cnt_i(cnt_i), .upd_i(upd_i), .dir_i(dir_i),
        .oc_mode_i(oc_mode_i), .preload_en_i(preload_en_i), .wr_i(wr_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .cap_evt_i(cap_evt_i),
        .clr_cc_i(clr_cc_i), .clr_ovc_i(clr_ovc_i), .ch_out_o(ch_out_o),
        .cc_flag_o(cc_flag_o), .ovc_flag_o(ovc_flag_o)
    );

    typedef struct packed {
        logic        dir;
        logic        pe;
        logic [1:0]  mode;
        logic        wr;
        logic [15:0] wd;
        logic        upd;
        logic [15:0] cnt;
        logic        cap;
        logic        clr;
        logic        e_out;
        logic        e_flag;
        logic        e_ovc;
        logic [15:0] e_rd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    // Mode codes: 0 hold, 1 toggle, 2 PWM, 3 inverted PWM.
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,2'd2,1'b1,16'd100,1'b0,16'd5,   1'b0,1'b0, 1'b0,1'b0,1'b0,16'd100, 8'd2},  // R2 write, threshold 0 used
        '{1'b0,1'b0,2'd2,1'b0,16'd0,  1'b0,16'd50,  1'b0,1'b0, 1'b1,1'b0,1'b0,16'd100, 8'd2},  // R2 new threshold in use
        '{1'b0,1'b0,2'd2,1'b0,16'd0,  1'b0,16'd100, 1'b0,1'b0, 1'b0,1'b1,1'b0,16'd100, 8'd6},  // R6 match, R4 equal -> low
        '{1'b0,1'b0,2'd2,1'b0,16'd0,  1'b0,16'd101, 1'b0,1'b0, 1'b0,1'b1,1'b0,16'd100, 8'd6},  // R6 sticky
        '{1'b0,1'b0,2'd2,1'b0,16'd0,  1'b0,16'd7,   1'b0,1'b1, 1'b1,1'b0,1'b0,16'd100, 8'd6},  // R6 clear
        '{1'b0,1'b0,2'd3,1'b0,16'd0,  1'b0,16'd7,   1'b0,1'b0, 1'b0,1'b0,1'b0,16'd100, 8'd4},  // R4 inverted below
        '{1'b0,1'b0,2'd3,1'b0,16'd0,  1'b0,16'd200, 1'b0,1'b0, 1'b1,1'b0,1'b0,16'd100, 8'd4},  // R4 inverted above
        '{1'b0,1'b1,2'd2,1'b1,16'd20, 1'b0,16'd50,  1'b0,1'b0, 1'b1,1'b0,1'b0,16'd20,  8'd3},  // R3 write to shadow only
        '{1'b0,1'b1,2'd2,1'b0,16'd0,  1'b0,16'd50,  1'b0,1'b0, 1'b1,1'b0,1'b0,16'd20,  8'd3},  // R3 threshold still 100
        '{1'b0,1'b1,2'd2,1'b0,16'd0,  1'b1,16'd50,  1'b0,1'b0, 1'b1,1'b0,1'b0,16'd20,  8'd3},  // R3 update pulse
        '{1'b0,1'b1,2'd2,1'b0,16'd0,  1'b0,16'd50,  1'b0,1'b0, 1'b0,1'b0,1'b0,16'd20,  8'd3},  // R3 threshold now 20
        '{1'b0,1'b1,2'd1,1'b0,16'd0,  1'b0,16'd20,  1'b0,1'b0, 1'b1,1'b1,1'b0,16'd20,  8'd5},  // R5 toggle up
        '{1'b0,1'b1,2'd1,1'b0,16'd0,  1'b0,16'd20,  1'b0,1'b0, 1'b0,1'b1,1'b0,16'd20,  8'd5},  // R5 toggle down
        '{1'b0,1'b1,2'd0,1'b0,16'd0,  1'b0,16'd20,  1'b0,1'b1, 1'b0,1'b1,1'b0,16'd20,  8'd6},  // R5 hold, R6 set wins
        '{1'b0,1'b1,2'd0,1'b0,16'd0,  1'b0,16'd3,   1'b0,1'b1, 1'b0,1'b0,1'b0,16'd20,  8'd6},  // R6 clear
        '{1'b1,1'b0,2'd2,1'b0,16'd0,  1'b0,16'd1234,1'b1,1'b0, 1'b0,1'b1,1'b0,16'd1234,8'd7},  // R7 capture
        '{1'b1,1'b0,2'd2,1'b0,16'd0,  1'b0,16'd5,   1'b0,1'b1, 1'b0,1'b0,1'b0,16'd1234,8'd7},  // R7 value kept
        '{1'b1,1'b0,2'd2,1'b1,16'd999,1'b0,16'd20,  1'b0,1'b0, 1'b0,1'b0,1'b0,16'd1234,8'd9},  // R9 write dropped, R10 no match flag
        '{1'b1,1'b0,2'd2,1'b0,16'd0,  1'b0,16'd4000,1'b1,1'b0, 1'b0,1'b1,1'b0,16'd4000,8'd7},  // R7 capture
        '{1'b1,1'b0,2'd2,1'b0,16'd0,  1'b0,16'd4001,1'b1,1'b0, 1'b0,1'b1,1'b1,16'd4001,8'd8},  // R8 overcapture
        '{1'b1,1'b0,2'd2,1'b0,16'd0,  1'b0,16'd0,   1'b0,1'b0, 1'b0,1'b1,1'b1,16'd4001,8'd10}  // R10 output low
    };

    task automatic check(input int req, input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL R%0d %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic idle();
        upd_i = 0; wr_i = 0; wdata_i = 0; cap_evt_i = 0; clr_cc_i = 0; clr_ovc_i = 0;
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1; cnt_i = 0; dir_i = 0; oc_mode_i = 2'd2; preload_en_i = 0;
        idle();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check(1, "rdata after reset", rdata_o, 16'd0);
        check(1, "out after reset", {15'd0, ch_out_o}, 16'd0);
        check(1, "flag after reset", {15'd0, cc_flag_o}, 16'd0);
        check(1, "ovc after reset", {15'd0, ovc_flag_o}, 16'd0);
        cnt_i = 16'd5;

        for (int i = 0; i < NV; i++) begin
            dir_i = TBL[i].dir; preload_en_i = TBL[i].pe; oc_mode_i = TBL[i].mode;
            wr_i = TBL[i].wr; wdata_i = TBL[i].wd; upd_i = TBL[i].upd;
            cnt_i = TBL[i].cnt; cap_evt_i = TBL[i].cap; clr_cc_i = TBL[i].clr;
            clr_ovc_i = 0;
            @(negedge clk);
            check(TBL[i].req, $sformatf("row %0d out", i), {15'd0, ch_out_o}, {15'd0, TBL[i].e_out});
            check(TBL[i].req, $sformatf("row %0d flag", i), {15'd0, cc_flag_o}, {15'd0, TBL[i].e_flag});
            check(TBL[i].req, $sformatf("row %0d ovc", i), {15'd0, ovc_flag_o}, {15'd0, TBL[i].e_ovc});
            check(TBL[i].req, $sformatf("row %0d rdata", i), rdata_o, TBL[i].e_rd);
        end

        // R8 overcapture cleared by its own clear only
        idle(); dir_i = 1; clr_ovc_i = 1; cnt_i = 16'd9;
        @(negedge clk);
        check(8, "ovc cleared", {15'd0, ovc_flag_o}, 16'd0);
        check(8, "flag kept on ovc clear", {15'd0, cc_flag_o}, 16'd1);

        // R2 boundary: immediate load of the largest threshold
        idle(); dir_i = 0; preload_en_i = 0; oc_mode_i = 2'd2;
        wr_i = 1; wdata_i = 16'hFFFF; cnt_i = 16'hFFFE;
        @(negedge clk);
        idle(); cnt_i = 16'hFFFE;
        @(negedge clk);
        check(2, "out below max threshold", {15'd0, ch_out_o}, 16'd1);
        check(2, "rdata max", rdata_o, 16'hFFFF);
        cnt_i = 16'hFFFF;
        @(negedge clk);
        check(4, "out at max threshold", {15'd0, ch_out_o}, 16'd0);

        // R1 reset in the middle of operation
        cnt_i = 16'd3;
        rst = 1;
        @(negedge clk);
        rst = 0;
        check(1, "rdata after mid reset", rdata_o, 16'd0);
        check(1, "flag after mid reset", {15'd0, cc_flag_o}, 16'd0);
        check(1, "out after mid reset", {15'd0, ch_out_o}, 16'd0);
        // R1 threshold 0: counter 3 is not below it
        @(negedge clk);
        check(1, "threshold zero after reset", {15'd0, ch_out_o}, 16'd0);

        summary();
        $finish;
    end

endmodule